// File: doc/BRIEF.md
# Keyed-write watchdog timer

This block is a memory-mapped watchdog. A 16-bit up-counter advances once per prescaled tick while the timer is enabled. When it wraps from 0xFFFF to 0 the block raises a reset-request pulse for the system reset logic. Software arms the timer by loading a start value and then setting the enable bit. The time to expiry is therefore (65536 − loaded value) ticks. Software keeps the system alive by reloading the counter before it wraps. Loading 0xFFFF while the timer runs forces a wrap on the very next tick, which gives software an immediate restart.

Software reaches the block through a 32-bit write and read port with three word registers: the counter at byte offset 0, control A at offset 4 and control B at offset 8. A write is accepted only when its upper bits carry that register's key. After each accepted write a short busy window follows, and during that window further writes are dropped. A sticky overflow flag records that the watchdog expired. This flag is cleared only by power-on reset or by software, so it survives the system reset that the expiry itself causes.

Top module: `wdk_top`

## Requirements
- R1: After power-on reset (porN low), counter reads 0, control A reads 0x00, control B reads 0x00 and rstReq is low.
- R2: A write to offset 0 with bits 31:16 equal to 0x5A5A loads bits 15:0 into the counter. A read of offset 0 returns the counter in bits 15:0 with bits 31:16 zero, at any time, including while counting.
- R3: A write whose key is wrong is dropped. For offsets 4 and 8 the key is bits 31:8 equal to 0xA5A5A5; for offset 0 the key is as in R2. A dropped write leaves the counter, control A and control B unchanged.
- R4: Control A bit 5 (read-only) is high for the 3 clock cycles after an accepted write. Writes sampled while it is high are dropped.
- R5: Control A bits 2:0 select the tick period in clock cycles: 0→1, 1→4, 2→16, 3→32, 4→64, 5→128, 6→1024, 7→4096.
- R6: Control A bit 7 enables counting, and the counter holds while it is clear. rstReq rises exactly P×(65536−L) cycles after the accepted write that sets bit 7, where P is the tick period and L is the loaded value.
- R7: On a wrap, rstReq is high for exactly 16 cycles, the enable bit clears and the counter reads 0.
- R8: Control A bit 4 is set by a wrap. A system reset (rstN low) does not clear it. It is cleared by an accepted control A write with bit 4 equal to 0, or by porN low. A control A write with bit 4 equal to 1 leaves it set.
- R9: The tick phase restarts on every accepted counter write and whenever enable goes from 0 to 1. A load of 0xFFFF while running therefore wraps exactly P cycles after the write.
- R10: Control B stores bits 7:0 of an accepted write, reads back in bits 7:0, and has no effect on timing.
- R11: A system reset (rstN low) clears the counter, control A bits 7 and 2:0, and control B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, synchronous; clears everything including the overflow flag |
| rstN | input | 1 | System reset, active low, synchronous; spares the overflow flag and an active pulse |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 4 | Byte address of the register |
| busWdata | input | 32 | Write data including key |
| busRdata | output | 32 | Read data for busAddr, combinational |
| rstReq | output | 1 | Reset-request pulse |

## Verification
The bench measures the time from the enabling write to the rising edge of rstReq for every prescaler setting. A design that failed to restart the tick phase on enable, or that was off by one in its prescaler compare, would produce a cycle count that differs from P×(65536−L). A load of 0xFFFF in the middle of a tick period targets the phase restart: without the restart, the wrap would arrive early. The busy window is probed edge by edge with a write inside it that must be lost. Wrong-key writes are followed by readback, so that a design leaking such a write into a register would show a changed value. The overflow flag is exercised through a system reset, a write with bit 4 set and a write with bit 4 clear, and then power-on reset. A design that tied the flag to the wrong reset would lose it or keep it at the wrong moment.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int CTL_W  = 8;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 12;
  localparam int NUM_REGS = 3;

  localparam logic [DATA_W-CNT_W-1:0] CNT_KEY = 16'h5A5A;
  localparam logic [DATA_W-CTL_W-1:0] CTL_KEY = 24'hA5A5A5;

  localparam int EN_BIT   = 7;
  localparam int BUSY_BIT = 5;
  localparam int OVF_BIT  = 4;

  localparam int OFS_COUNT = 0;
  localparam int OFS_CTLA  = 4;
  localparam int OFS_CTLB  = 8;

  // Strobes from control to datapath, one per register, plus payload.
  typedef struct packed {
    logic             wrCount;
    logic             wrCtlA;
    logic             wrCtlB;
    logic [CNT_W-1:0] data;
  } wrStrobe_t;

  // Terminal value of the prescaler count for each select code.
  function automatic logic [PRE_W-1:0] divLimit(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: divLimit = PRE_W'(0);
      3'd1: divLimit = PRE_W'(3);
      3'd2: divLimit = PRE_W'(15);
      3'd3: divLimit = PRE_W'(31);
      3'd4: divLimit = PRE_W'(63);
      3'd5: divLimit = PRE_W'(127);
      3'd6: divLimit = PRE_W'(1023);
      default: divLimit = PRE_W'(4095);
    endcase
  endfunction
endpackage

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
  import wdk_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output wrStrobe_t         str,
  output logic              busy
);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);
  localparam int OFS [NUM_REGS] = '{OFS_COUNT, OFS_CTLA, OFS_CTLB};

  logic [BUSY_W-1:0]   busyCnt;
  logic [NUM_REGS-1:0] hit;
  logic                accept;

  // Per-register address match and key check.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_key
    if (i == 0) begin : g_cnt
      assign hit[i] = (busAddr == ADDR_W'(OFS[i])) &&
                      (busWdata[DATA_W-1:CNT_W] == CNT_KEY);
    end else begin : g_ctl
      assign hit[i] = (busAddr == ADDR_W'(OFS[i])) &&
                      (busWdata[DATA_W-1:CTL_W] == CTL_KEY);
    end
  end

  assign busy   = (busyCnt != '0);
  assign accept = busWe && !busy && (hit != '0);

  always_comb begin
    str.wrCount = accept && hit[0];
    str.wrCtlA  = accept && hit[1];
    str.wrCtlB  = accept && hit[2];
    str.data    = busWdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN)  busyCnt <= '0;
    else if (accept)     busyCnt <= BUSY_W'(BUSY_CYC);
    else if (busy)       busyCnt <= busyCnt - 1'b1;
  end

  // R4: an accepted write opens the busy window on the next cycle.
  a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (str.wrCount || str.wrCtlA || str.wrCtlB) |=> busy);
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
  import wdk_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             tick
);
  logic [PRE_W-1:0] preCnt;

  // >= keeps the tick alive if the ratio shrinks mid-period.
  assign tick = enable && (preCnt >= divLimit(sel));

  always_ff @(posedge clk) begin
    if (!porN || !rstN)  preCnt <= '0;
    else if (restart)    preCnt <= '0;
    else if (tick)       preCnt <= '0;
    else if (enable)     preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/wdk_datapath.sv
module wdk_datapath
  import wdk_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  wrStrobe_t         str,
  input  logic              tick,
  input  logic              busy,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              enable,
  output logic [SEL_W-1:0]  cks,
  output logic              restart,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq
);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0]   count;
  logic [CTL_W-1:0]   ctlB;
  logic               ovfFlag;
  logic [PULSE_W-1:0] pulseCnt;
  logic               ovfEvent;
  logic [CTL_W-1:0]   ctlAView;

  assign ovfEvent = tick && (count == {CNT_W{1'b1}});
  assign restart  = str.wrCount || (str.wrCtlA && str.data[EN_BIT] && !enable);
  assign rstReq   = (pulseCnt != '0);

  // Registers cleared by either reset; a write beats the tick.
  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      count  <= '0;
      enable <= 1'b0;
      cks    <= '0;
      ctlB   <= '0;
    end else begin
      if (str.wrCount)  count <= str.data;
      else if (tick)    count <= count + 1'b1;
      if (str.wrCtlA) begin
        enable <= str.data[EN_BIT];
        cks    <= str.data[SEL_W-1:0];
      end else if (ovfEvent) begin
        enable <= 1'b0;
      end
      if (str.wrCtlB)   ctlB <= str.data[CTL_W-1:0];
    end
  end

  // State that must outlive the reset the watchdog itself requests.
  always_ff @(posedge clk) begin
    if (!porN) begin
      ovfFlag  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (ovfEvent)                              ovfFlag <= 1'b1;
      else if (str.wrCtlA && !str.data[OVF_BIT]) ovfFlag <= 1'b0;
      if (ovfEvent)     pulseCnt <= PULSE_W'(PULSE_LEN);
      else if (rstReq)  pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    ctlAView = '0;
    ctlAView[EN_BIT]    = enable;
    ctlAView[BUSY_BIT]  = busy;
    ctlAView[OVF_BIT]   = ovfFlag;
    ctlAView[SEL_W-1:0] = cks;
  end

  always_comb begin
    rdData = '0;
    if (busAddr == ADDR_W'(OFS_COUNT))     rdData[CNT_W-1:0] = count;
    else if (busAddr == ADDR_W'(OFS_CTLA)) rdData[CTL_W-1:0] = ctlAView;
    else if (busAddr == ADDR_W'(OFS_CTLB)) rdData[CTL_W-1:0] = ctlB;
  end

  // R6: no tick while disabled, so the count holds unless written.
  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!enable && !str.wrCount) |=> (count == $past(count)));
  // R7: a wrap always raises the request on the next cycle.
  a_r7_req_follows_wrap: assert property (@(posedge clk) disable iff (!porN)
    ovfEvent |=> rstReq);
  // R7: a wrap clears the enable unless software writes control A then.
  a_r7_enable_drops: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (ovfEvent && !str.wrCtlA) |=> !enable);
  // R8: the flag stays set until a clearing write or power-on reset.
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!porN)
    (ovfFlag && !(str.wrCtlA && !str.data[OVF_BIT])) |=> ovfFlag);
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BUSY_CYC  = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              rstReq
);
  wrStrobe_t        str;
  logic             busy;
  logic             enable;
  logic [SEL_W-1:0] cks;
  logic             restart;
  logic             tick;

  wdk_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .str(str), .busy(busy)
  );

  wdk_prescaler u_pre (
    .clk(clk), .porN(porN), .rstN(rstN), .enable(enable), .sel(cks),
    .restart(restart), .tick(tick)
  );

  wdk_datapath #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .porN(porN), .rstN(rstN), .str(str), .tick(tick), .busy(busy),
    .busAddr(busAddr), .enable(enable), .cks(cks), .restart(restart),
    .rdData(busRdata), .rstReq(rstReq)
  );
endmodule

// File: tb/wdk_top_test.sv
`timescale 1ns/1ps
module wdk_top_test;
  logic        clk = 1'b0;
  logic        porN, rstN, busWe, rstReq;
  logic [3:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 0;

  wdk_top uut (
    .clk(clk), .porN(porN), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    while (!rstReq && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic pulseLen(output int m);
    m = 0;
    while (rstReq && m < 100) begin @(negedge clk); m++; end
  endtask

  task automatic tReset;
    logic [31:0] v;
    porN = 0; rstN = 0; busWe = 0; busAddr = 0; busWdata = 0;
    idle(3);
    porN = 1; rstN = 1;
    idle(1);
    check("R1 rstReq", {31'b0, rstReq}, 32'h0);
    readReg(4'h0, v); check("R1 count", v, 32'h0);
    readReg(4'h4, v); check("R1 ctlA", v, 32'h0);
    readReg(4'h8, v); check("R1 ctlB", v, 32'h0);
  endtask

  task automatic tKeys;
    logic [31:0] v;
    idle(4);
    doWrite(4'h0, 32'h5A5A_1234); idle(3);
    readReg(4'h0, v); check("R2 count load", v, 32'h0000_1234);
    doWrite(4'h0, 32'h1234_BEEF); idle(3);
    readReg(4'h0, v); check("R3 count bad key", v, 32'h0000_1234);
    doWrite(4'h4, 32'hA5A5_A487); idle(3);
    readReg(4'h4, v); check("R3 ctlA bad key", v, 32'h0);
    idle(5);
    readReg(4'h0, v); check("R3 no enable from bad key", v, 32'h0000_1234);
    doWrite(4'h8, 32'hA5A5_A53C); idle(3);
    readReg(4'h8, v); check("R10 ctlB store", v, 32'h3C);
    doWrite(4'h8, 32'h5A5A_A5C3); idle(3);
    readReg(4'h8, v); check("R3 ctlB bad key", v, 32'h3C);
  endtask

  task automatic tBusy;
    logic [31:0] v;
    idle(4);
    doWrite(4'h0, 32'h5A5A_0100);
    readReg(4'h4, v); check("R4 busy set", v & 32'h20, 32'h20);
    doWrite(4'h0, 32'h5A5A_0200);
    readReg(4'h4, v); check("R4 busy cycle 2", v & 32'h20, 32'h20);
    idle(1);
    readReg(4'h4, v); check("R4 busy cycle 3", v & 32'h20, 32'h20);
    idle(1);
    readReg(4'h4, v); check("R4 busy clear", v & 32'h20, 32'h0);
    readReg(4'h0, v); check("R4 write in window dropped", v, 32'h0000_0100);
  endtask

  task automatic tTimeout(input logic [2:0] sel, input logic [15:0] ld, input int exp);
    logic [31:0] v;
    int n, m;
    idle(4);
    doWrite(4'h0, {16'h5A5A, ld}); idle(3);
    doWrite(4'h4, {24'hA5A5A5, 5'b10000, sel});
    waitReq(n);
    check($sformatf("R6 R5 timeout sel %0d", sel), n, exp);
    pulseLen(m);
    check("R7 pulse length", m, 16);
    readReg(4'h4, v); check("R7 R8 ctlA after wrap", v, {24'h0, 5'b00010, sel});
    readReg(4'h0, v); check("R7 count after wrap", v, 32'h0);
  endtask

  task automatic tRunStop;
    logic [31:0] v;
    idle(4);
    doWrite(4'h0, 32'h5A5A_1000); idle(3);
    doWrite(4'h4, 32'hA5A5_A580);
    idle(10);
    readReg(4'h0, v); check("R2 read while running", v, 32'h0000_100A);
    doWrite(4'h4, 32'hA5A5_A500);
    readReg(4'h0, v); check("R6 last tick at disable", v, 32'h0000_100B);
    idle(5);
    readReg(4'h0, v); check("R6 hold when disabled", v, 32'h0000_100B);
  endtask

  task automatic tForce;
    int n, m;
    idle(4);
    doWrite(4'h0, 32'h5A5A_0000); idle(3);
    doWrite(4'h4, 32'hA5A5_A582);
    idle(5);
    doWrite(4'h0, 32'h5A5A_FFFF);
    waitReq(n);
    check("R9 forced wrap after restart", n, 16);
    pulseLen(m);
  endtask

  task automatic tFlag;
    logic [31:0] v;
    idle(2);
    rstN = 0; idle(2); rstN = 1; idle(1);
    readReg(4'h4, v); check("R8 R11 flag survives system reset", v, 32'h10);
    readReg(4'h0, v); check("R11 count cleared", v, 32'h0);
    readReg(4'h8, v); check("R11 ctlB cleared", v, 32'h0);
    doWrite(4'h4, 32'hA5A5_A510); idle(3);
    readReg(4'h4, v); check("R8 write bit4=1 keeps flag", v, 32'h10);
    doWrite(4'h4, 32'hA5A5_A500); idle(3);
    readReg(4'h4, v); check("R8 write bit4=0 clears flag", v, 32'h0);
    tTimeout(3'd0, 16'hFFFF, 1);
    porN = 0; idle(2); porN = 1; idle(1);
    readReg(4'h4, v); check("R8 R1 power-on clears flag", v, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);
    tReset();
    tKeys();
    tBusy();
    tTimeout(3'd0, 16'hFFF0, 16);
    tTimeout(3'd1, 16'hFFF8, 32);
    tTimeout(3'd2, 16'hFFFC, 64);
    tTimeout(3'd3, 16'hFFFC, 128);
    tTimeout(3'd4, 16'hFFFE, 128);
    tTimeout(3'd5, 16'hFFFF, 128);
    tTimeout(3'd6, 16'hFFFE, 2048);
    tTimeout(3'd7, 16'hFFFE, 8192);
    readReg(4'h8, v); check("R10 ctlB unchanged by runs", v, 32'h3C);
    tRunStop();
    tForce();
    tFlag();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule